// File: doc/BRIEF.md
# Direct-Mapped Word Cache with Isolated Diagnostic Access

This block holds the tag and data store of a direct-mapped cache with one 32-bit word per line, placed between a simple processor's load/store path and memory. Each request is looked up in the line selected by its low word-address bits. The stored tag is compared against the address bits above the cache size. In normal operation, read misses refill the line from a memory port, and writes go through to memory.

A second way of working lets software test the cache array directly. When the request carries the isolate flag, the request never reaches memory. Three address bits at the top are ignored. A load returns whatever the selected line holds and records a true tag miss in a sticky status flag. A full-word store installs the word and tag as a valid line. A store narrower than a word invalidates the line. A parity-error status flag is set by a refill that reports bad parity and is cleared by any later lookup.

Top module: `isoc_cache`

## Requirements
- R1: After reset every line is invalid with zero tag and data, `req_ready` is 1, and `stat_miss`, `stat_perr` and `rsp_valid` are 0.
- R2: With 2^IDX_W lines, the line index is address bits [IDX_W+1:2] and the tag is the bits above them. A lookup hits only if the line is valid and its stored tag equals the request tag.
- R3: Every accepted request clears `stat_perr`. A refill completed with `mem_perr` high sets `stat_perr`, and the flag stays set until the next accepted request.
- R4: A request with `req_isolate` high never raises `mem_rd_req` or `mem_wr_req`.
- R5: An isolated load answers with `rsp_valid` on the cycle after acceptance. Its `rsp_rdata` is the data word of the selected line, whether the lookup hits or misses.
- R6: An isolated load whose lookup misses sets `stat_miss`. A hit leaves the flag unchanged.
- R7: `stat_miss` holds its value until a cycle with `stat_clr` high clears it. If a miss is being recorded in that same cycle, the set takes priority over the clear.
- R8: An isolated store with `req_be` = 4'b1111 writes the word and the request tag into the selected line and marks the line valid.
- R9: An isolated store with any other byte-enable value marks the selected line invalid.
- R10: In isolated mode, address bits 31:29 are treated as zero before index and tag are formed.
- R11: A normal load that hits answers on the next cycle without memory traffic. A normal load that misses holds `mem_rd_req` with the request address until `mem_ack`, installs `mem_rdata` as a valid line, and returns it with `rsp_valid` on the cycle after `mem_ack`.
- R12: A normal store holds `mem_wr_req` with its address, data and byte enables until `mem_ack`, then answers with `rsp_valid`. In the cache, a full-word store installs a valid line, a partial store that hits merges the enabled bytes, and a partial store that misses leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_isolate | input | 1 | Request addresses the cache array only |
| req_addr | input | 32 | Byte address |
| req_be | input | 4 | Byte enables of a store, bit i for byte lane i |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid |
| stat_clr | input | 1 | Clears the sticky miss flag |
| stat_miss | output | 1 | Sticky isolated-lookup miss flag |
| stat_perr | output | 1 | Parity error seen on the last refill |
| mem_rd_req | output | 1 | Refill read pending |
| mem_wr_req | output | 1 | Write-through store pending |
| mem_addr | output | 32 | Memory address of the pending access |
| mem_be | output | 4 | Byte enables of the pending store |
| mem_wdata | output | 32 | Data of the pending store |
| mem_rdata | input | 32 | Refill data, valid with mem_ack |
| mem_ack | input | 1 | Completes the pending memory access |
| mem_perr | input | 1 | Refill data failed its parity check |

## Verification
The bound checker checks on every cycle the rules that follow from the ports alone. Isolated requests never start memory traffic. Acceptance clears the parity flag, and an isolated request answers on the next cycle. The miss flag stays set unless a clear arrives. A pending memory access keeps its address until it is acknowledged, and reads and writes never overlap. What the array holds cannot be seen from a single cycle, so only the bench's sweeps can show it. These sweeps cover installing and invalidating lines, segment stripping that makes aliased addresses hit, merging of partial stores, refill contents, and the true hit/miss reported for every line. The bench compares each response against its own line model.

// File: rtl/isoc_pkg.sv
package isoc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_WTHRU = 2'd2
   } isoc_state_e;

   localparam int unsigned WORD_OFS_W = 2;
endpackage

// File: rtl/isoc_addr_split.sv
module isoc_addr_split #(
   parameter int unsigned WORD_W = 30,
   parameter int unsigned IDX_W  = 4,
   localparam int unsigned TAG_W = WORD_W - IDX_W
) (
   input  logic [WORD_W-1:0] word_addr,
   output logic [IDX_W-1:0]  idx,
   output logic [TAG_W-1:0]  tag
);
   assign idx = word_addr[IDX_W-1:0];
   assign tag = word_addr[WORD_W-1:IDX_W];
endmodule

// File: rtl/isoc_line_store.sv
module isoc_line_store #(
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned TAG_W  = 26,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned LINES = 1 << IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_vld
);
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];
   logic              vld_q  [LINES];

   for (genvar gi = 0; gi < LINES; gi++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q[gi]  <= '0;
            data_q[gi] <= '0;
            vld_q[gi]  <= 1'b0;
         end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
            tag_q[gi]  <= wr_tag;
            data_q[gi] <= wr_data;
            vld_q[gi]  <= wr_vld;
         end
      end
   end

   assign rd_tag  = tag_q[rd_idx];
   assign rd_data = data_q[rd_idx];
   assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/isoc_status.sv
module isoc_status (
   input  logic clk,
   input  logic rst_n,
   input  logic lookup,
   input  logic perr_set,
   input  logic miss_set,
   input  logic miss_clr,
   output logic stat_miss,
   output logic stat_perr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_miss <= 1'b0;
         stat_perr <= 1'b0;
      end else begin
         if (miss_set)      stat_miss <= 1'b1;
         else if (miss_clr) stat_miss <= 1'b0;
         if (perr_set)      stat_perr <= 1'b1;
         else if (lookup)   stat_perr <= 1'b0;
      end
   end
endmodule

// File: rtl/isoc_cache.sv
module isoc_cache
   import isoc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IDX_W    = 4,
   parameter int unsigned SEG_BITS = 3,
   localparam int unsigned BYTES   = DATA_W / 8,
   localparam int unsigned WORD_W  = ADDR_W - WORD_OFS_W,
   localparam int unsigned TAG_W   = WORD_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_isolate,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [BYTES-1:0]  req_be,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic              stat_clr,
   output logic              stat_miss,
   output logic              stat_perr,
   output logic              mem_rd_req,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTES-1:0]  mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ack,
   input  logic              mem_perr
);
   localparam logic [WORD_W-1:0] SEG_KEEP = {WORD_W{1'b1}} >> SEG_BITS;

   initial begin
      assert (DATA_W == 8 * (1 << WORD_OFS_W))
         else $fatal(1, "isoc_cache: DATA_W must match the word offset");
      assert (IDX_W >= 1 && IDX_W + SEG_BITS < WORD_W)
         else $fatal(1, "isoc_cache: IDX_W out of range");
      assert (SEG_BITS < WORD_W)
         else $fatal(1, "isoc_cache: SEG_BITS too large");
   end

   isoc_state_e state_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [BYTES-1:0]  lat_be_q;
   logic [DATA_W-1:0] lat_wdata_q;
   logic [IDX_W-1:0]  lat_idx_q;
   logic [TAG_W-1:0]  lat_tag_q;
   logic              rsp_valid_q;
   logic [DATA_W-1:0] rsp_data_q;

   logic              accept;
   logic [WORD_W-1:0] eff_word;
   logic [IDX_W-1:0]  q_idx;
   logic [TAG_W-1:0]  q_tag;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_data;
   logic              rd_vld;
   logic              hit;
   logic              full_word;
   logic [DATA_W-1:0] merged;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [TAG_W-1:0]  wr_tag;
   logic [DATA_W-1:0] wr_data;
   logic              wr_vld;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;

   // segment bits are dropped only for diagnostic access
   assign eff_word = req_isolate ? (req_addr[ADDR_W-1:WORD_OFS_W] & SEG_KEEP)
                                 : req_addr[ADDR_W-1:WORD_OFS_W];

   isoc_addr_split #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_split (
      .word_addr (eff_word),
      .idx       (q_idx),
      .tag       (q_tag)
   );

   isoc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (q_idx),
      .rd_tag  (rd_tag),
      .rd_data (rd_data),
      .rd_vld  (rd_vld),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_data (wr_data),
      .wr_vld  (wr_vld)
   );

   assign hit       = rd_vld && (rd_tag == q_tag);
   assign full_word = &req_be;

   for (genvar gb = 0; gb < BYTES; gb++) begin : g_merge
      assign merged[8*gb +: 8] = req_be[gb] ? req_wdata[8*gb +: 8] : rd_data[8*gb +: 8];
   end

   always_comb begin
      wr_en   = 1'b0;
      wr_idx  = q_idx;
      wr_tag  = q_tag;
      wr_data = req_wdata;
      wr_vld  = 1'b1;
      if (accept && req_write) begin
         if (req_isolate) begin
            wr_en = 1'b1;
            if (!full_word) begin
               wr_tag  = rd_tag;
               wr_data = rd_data;
               wr_vld  = 1'b0;
            end
         end else if (full_word) begin
            wr_en = 1'b1;
         end else if (hit) begin
            wr_en   = 1'b1;
            wr_data = merged;
         end
      end else if (state_q == ST_FILL && mem_ack) begin
         wr_en   = 1'b1;
         wr_idx  = lat_idx_q;
         wr_tag  = lat_tag_q;
         wr_data = mem_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         lat_addr_q  <= '0;
         lat_be_q    <= '0;
         lat_wdata_q <= '0;
         lat_idx_q   <= '0;
         lat_tag_q   <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         rsp_valid_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  lat_addr_q  <= req_addr;
                  lat_be_q    <= req_be;
                  lat_wdata_q <= req_wdata;
                  lat_idx_q   <= q_idx;
                  lat_tag_q   <= q_tag;
                  if (req_isolate) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= req_write ? '0 : rd_data;
                  end else if (req_write) begin
                     state_q <= ST_WTHRU;
                  end else if (hit) begin
                     rsp_valid_q <= 1'b1;
                     rsp_data_q  <= rd_data;
                  end else begin
                     state_q <= ST_FILL;
                  end
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= mem_rdata;
                  state_q     <= ST_IDLE;
               end
            end
            ST_WTHRU: begin
               if (mem_ack) begin
                  rsp_valid_q <= 1'b1;
                  rsp_data_q  <= '0;
                  state_q     <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   isoc_status u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .lookup    (accept),
      .perr_set  (state_q == ST_FILL && mem_ack && mem_perr),
      .miss_set  (accept && req_isolate && !req_write && !hit),
      .miss_clr  (stat_clr),
      .stat_miss (stat_miss),
      .stat_perr (stat_perr)
   );

   assign rsp_valid  = rsp_valid_q;
   assign rsp_rdata  = rsp_data_q;
   assign mem_rd_req = (state_q == ST_FILL);
   assign mem_wr_req = (state_q == ST_WTHRU);
   assign mem_addr   = lat_addr_q;
   assign mem_be     = lat_be_q;
   assign mem_wdata  = lat_wdata_q;
endmodule

// File: rtl/isoc_cache_chk.sv
module isoc_cache_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_write,
   input logic              req_isolate,
   input logic              stat_clr,
   input logic              stat_miss,
   input logic              stat_perr,
   input logic              rsp_valid,
   input logic              mem_rd_req,
   input logic              mem_wr_req,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr
);
   logic acc;
   assign acc = req_valid && req_ready;

   p_iso_no_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_isolate |=> !mem_rd_req && !mem_wr_req);

   p_perr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> !stat_perr);

   p_iso_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_isolate |=> rsp_valid);

   p_miss_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_miss && !stat_clr |=> stat_miss);

   p_miss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr && !(acc && req_isolate && !req_write) |=> !stat_miss);

   p_fill_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req && !mem_ack |=> mem_rd_req && $stable(mem_addr));

   p_wthru_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req && !mem_ack |=> mem_wr_req && $stable(mem_addr));

   p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));
endmodule

bind isoc_cache isoc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/isoc_cache_tb.sv
module isoc_cache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_isolate = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        stat_clr = 1'b0;
   logic        stat_miss;
   logic        stat_perr;
   logic        mem_rd_req;
   logic        mem_wr_req;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        mem_ack = 1'b0;
   logic        mem_perr;

   always #4 clk = ~clk;

   isoc_cache dut_i (.*);

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit perr_mode = 1'b0;

   // memory stub
   int rd_cnt = 0, wr_cnt = 0, wait_cnt = 0;
   logic [31:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
   logic [3:0]  last_wr_be = '0;

   function automatic logic [31:0] memfn(input logic [31:0] a);
      return a * 32'h9E37_79B1 + 32'h0123_4567;
   endfunction

   assign mem_rdata = memfn(mem_addr);
   assign mem_perr  = perr_mode;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      mem_ack <= 1'b0;
      if ((mem_rd_req || mem_wr_req) && !mem_ack) begin
         if (wait_cnt == 2) begin
            wait_cnt <= 0;
            mem_ack  <= 1'b1;
            if (mem_rd_req) begin
               rd_cnt <= rd_cnt + 1;
               last_rd_addr <= mem_addr;
            end else begin
               wr_cnt <= wr_cnt + 1;
               last_wr_addr <= mem_addr;
               last_wr_data <= mem_wdata;
               last_wr_be   <= mem_be;
            end
         end else begin
            wait_cnt <= wait_cnt + 1;
         end
      end
   end

   // reference line model: 16 lines, index = addr[5:2], tag = addr[31:6]
   logic [25:0] mt [16];
   logic [31:0] md [16];
   bit          mv [16];
   bit          msticky = 1'b0;
   bit          mperr   = 1'b0;

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      while (cycles < 150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
   end

   task automatic op(input bit iso, input bit wr, input logic [31:0] addr,
                     input logic [3:0] be, input logic [31:0] wd);
      logic [31:0] ea, erd;
      int idx, rd0, wr0, erdn, ewrn;
      logic [25:0] tg;
      bit mh;
      ea  = iso ? (addr & 32'h1FFF_FFFF) : addr;   // R10
      idx = int'(ea[5:2]);                         // R2
      tg  = ea[31:6];
      mh  = mv[idx] && (mt[idx] == tg);
      erd = '0; erdn = 0; ewrn = 0;
      mperr = 1'b0;
      if (iso) begin
         if (!wr) begin
            erd = md[idx];
            if (!mh) msticky = 1'b1;
         end else if (be == 4'hF) begin
            mt[idx] = tg; md[idx] = wd; mv[idx] = 1'b1;
         end else begin
            mv[idx] = 1'b0;
         end
      end else if (!wr) begin
         if (mh) erd = md[idx];
         else begin
            erdn = 1;
            erd = memfn(addr);
            mt[idx] = tg; md[idx] = erd; mv[idx] = 1'b1;
            mperr = perr_mode;
         end
      end else begin
         ewrn = 1;
         if (be == 4'hF) begin
            mt[idx] = tg; md[idx] = wd; mv[idx] = 1'b1;
         end else if (mh) begin
            for (int b = 0; b < 4; b++)
               if (be[b]) md[idx][8*b +: 8] = wd[8*b +: 8];
         end
      end
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      req_isolate = iso; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      if (!wr) chk(iso ? "R5" : "R11", "load data", rsp_rdata, erd);
      chk(iso ? "R4" : "R11", "refill count", rd_cnt - rd0, erdn);
      chk(iso ? "R4" : "R12", "store count", wr_cnt - wr0, ewrn);
      chk("R6", "miss flag", {31'd0, stat_miss}, {31'd0, msticky});
      chk("R3", "parity flag", {31'd0, stat_perr}, {31'd0, mperr});
      if (erdn == 1) chk("R11", "refill address", last_rd_addr, addr);
      if (ewrn == 1) begin
         chk("R12", "store address", last_wr_addr, addr);
         chk("R12", "store data", last_wr_data, wd);
         chk("R12", "store enables", {28'd0, last_wr_be}, {28'd0, be});
      end
   endtask

   task automatic clr();
      @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      msticky = 1'b0;
      chk("R7", "miss flag after clear", {31'd0, stat_miss}, 32'd0);
   endtask

   function automatic logic [31:0] a_of(input int tagv, input int idx);
      return (32'(tagv) << 6) | (32'(idx) << 2);
   endfunction

   initial begin
      for (int i = 0; i < 16; i++) begin mt[i] = '0; md[i] = '0; mv[i] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle state after reset
      chk("R1", "ready", {31'd0, req_ready}, 32'd1);
      chk("R1", "miss flag", {31'd0, stat_miss}, 32'd0);
      chk("R1", "parity flag", {31'd0, stat_perr}, 32'd0);
      chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);

      // R1/R5/R6: every line starts invalid, isolated loads miss and return zero
      for (int i = 0; i < 16; i++) begin
         op(1, 0, a_of(0, i), 4'hF, '0);
         clr();
      end

      // R8/R10: isolated full-word stores through a segment alias
      for (int i = 0; i < 16; i++)
         op(1, 1, 32'hA000_0000 | a_of(i * 7 + 1, i), 4'hF, (32'h0101_0101 * i) ^ 32'hC300_0000);

      // R10: other segment aliases hit; R5/R6: foreign tag returns data and misses
      for (int i = 0; i < 16; i++) begin
         op(1, 0, (32'(i % 8) << 29) | a_of(i * 7 + 1, i), 4'hF, '0);
         op(1, 0, a_of(i * 7 + 2, i), 4'hF, '0);
         clr();
      end

      // R9: partial isolated stores invalidate
      for (int i = 0; i < 16; i += 2) begin
         op(1, 1, a_of(i * 7 + 1, i), 4'(1 << (i % 4)) | 4'(i & 8), 32'hDEAD_BEEF);
         op(1, 0, a_of(i * 7 + 1, i), 4'hF, '0);
         clr();
      end

      // R11/R2: normal loads refill every line, then hit
      for (int i = 0; i < 16; i++) begin
         op(0, 0, a_of(32'h40 + i, i), 4'hF, '0);
         op(0, 0, a_of(32'h40 + i, i), 4'hF, '0);
      end

      // R3: parity error on refill, cleared by the next lookup
      perr_mode = 1'b1;
      op(0, 0, a_of(32'h99, 1), 4'hF, '0);
      perr_mode = 1'b0;
      op(1, 0, a_of(32'h99, 1), 4'hF, '0);

      // R12: write-through variants
      op(0, 1, a_of(32'h77, 3), 4'hF, 32'h1122_3344);
      op(0, 0, a_of(32'h77, 3), 4'hF, '0);
      op(0, 1, a_of(32'h77, 3), 4'b0101, 32'hAABB_CCDD);
      op(0, 0, a_of(32'h77, 3), 4'hF, '0);
      op(0, 1, a_of(32'h55, 5), 4'b0011, 32'h5555_6666);
      op(0, 0, a_of(32'h40 + 5, 5), 4'hF, '0);
      op(0, 0, a_of(32'h55, 5), 4'hF, '0);

      // R7: sticky across normal misses, then cleared
      op(1, 0, a_of(32'h3, 7), 4'hF, '0);
      op(0, 0, a_of(32'h123, 8), 4'hF, '0);
      clr();

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule